// File: doc/BRIEF.md
# Cubic B-spline deformation pipeline

This block maps 2-D image points through a free-form deformation defined by a grid of control-point displacements. Each incoming point carries two unsigned fixed-point coordinates. The integer parts select a cell of the control grid. The fraction parts address four cubic basis tables that are read side by side. Two pipelined multiplier banks form the sixteen tensor weights and then the sixteen weighted displacements for each axis. A three-stage adder tree sums and rounds them into one x and one y displacement.

The control-point grid sits in an external synchronous memory. One read returns the whole 4x4 window that belongs to a cell. The block issues that read partway down its pipeline, so the window data meets the weights in the cycle they are needed. Points arrive on a valid/ready stream and results leave on a valid/ready stream. A stalled output freezes the whole pipeline, and the stall reaches the input as a low `in_ready` in the same cycle. Once the pipeline is full, one point can be accepted every cycle.

Top module: `ffd_bspline_pipe`

## Requirements
- R1: A synchronous reset leaves `out_valid` low, `out_dx` and `out_dy` at zero and `in_ready` high, and it discards every point in flight.
- R2: `in_ready` equals `!out_valid || out_ready`. A point is taken on each rising edge where `in_valid` and `in_ready` are both high, and back-to-back points are taken on consecutive cycles.
- R3: With `out_ready` held high, the result for a point is presented on the 15th rising edge after the edge that took it. Results leave in the order the points arrived.
- R4: While `out_valid` is high and `out_ready` is low, the output holds its value and nothing is lost. `out_valid` falls only after a cycle in which `out_ready` was high.
- R5: Each point causes exactly one memory read. The read is issued with `cp_rd_en` high on the 6th pipeline advance after the point is taken, and only in a cycle where the pipeline advances. The address is `{v integer part, u integer part}`. The memory returns the data on the next edge and holds it while `cp_rd_en` is low.
- R6: Window element k = 4*j + i holds control point (i, j), where i runs along u and j along v. Its x displacement sits at bits [(2k)*16 +: 16] and its y displacement at bits [(2k+1)*16 +: 16]. Both are signed.
- R7: Basis table s (0 to 3) at index n, with N = 1024, holds round(num_s / (6 * 2^15)). The numerators are num0 = (N-n)^3, num1 = 3n^3 - 6n^2 N + 4N^3, num2 = -3n^3 + 3n^2 N + 3nN^2 + N^3 and num3 = n^3. Rounding adds half the divisor and then truncates.
- R8: The table index is the top 10 bits of the 12-bit fraction. The two lowest coordinate bits have no effect on the result.
- R9: The weight for term (i, j) is w = (Bi(u) * Bj(v) + 2^14) >> 15, an unsigned value.
- R10: Each output is floor((sum over i,j of w(i,j) * phi(i,j) + 2^14) / 2^15), in the same scale as the displacements.
- R11: A sum that falls outside the signed 16-bit range saturates to 32767 or -32768.
- R12: The x and y results are computed independently. Each uses only its own displacement field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A point is offered |
| in_ready | output | 1 | The block takes the offered point this cycle |
| in_u | input | 16 | Horizontal coordinate: 4 integer bits, 12 fraction bits |
| in_v | input | 16 | Vertical coordinate: 4 integer bits, 12 fraction bits |
| cp_rd_en | output | 1 | Control-window read strobe |
| cp_rd_addr | output | 8 | Cell address {v integer, u integer} |
| cp_rd_data | input | 512 | 4x4 window of signed x/y displacements, one edge after the read |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_dx | output | 16 | Signed x displacement |
| out_dy | output | 16 | Signed y displacement |

## Verification
A corrupted basis entry, a misrouted weight or a swapped window element shows up as a wrong `out_dx` or `out_dy` for the affected point. That happens exactly 15 cycles after the point was taken when there is no back-pressure. A valid bit lost or duplicated inside the pipeline appears at once as a missing or extra result in that same slot. A wrong stall path shows up within one cycle in one of three places: a changing held output, a wrong `in_ready`, or a memory read issued out of step.

// File: rtl/ffd_pkg.sv
package ffd_pkg;

  localparam int TAPS    = 4;
  localparam int TERMS   = TAPS * TAPS;
  localparam int MUL_LAT = 6;
  localparam int SUM_LAT = 3;

  // One cubic basis sample, scaled to wfrac fraction bits and rounded.
  function automatic longint basis_entry(input int sel, input int idx,
                                         input int aw, input int wfrac);
    longint n;
    longint t;
    longint num;
    longint den;
    n = longint'(1) << aw;
    t = longint'(idx);
    case (sel)
      0:       num = (n - t) * (n - t) * (n - t);
      1:       num = 3 * t * t * t - 6 * t * t * n + 4 * n * n * n;
      2:       num = -3 * t * t * t + 3 * t * t * n + 3 * t * n * n + n * n * n;
      default: num = t * t * t;
    endcase
    den = longint'(6) << (3 * aw - wfrac);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/ffd_basis_lut.sv
module ffd_basis_lut #(
  parameter int LUT_AW = 10,
  parameter int WB     = 16,
  parameter int WFRAC  = 15
) (
  input  logic [LUT_AW-1:0]                   idx_u,
  input  logic [LUT_AW-1:0]                   idx_v,
  output logic [ffd_pkg::TAPS-1:0][WB-1:0]    wu,
  output logic [ffd_pkg::TAPS-1:0][WB-1:0]    wv
);
  localparam int ENTRIES = 1 << LUT_AW;

  logic [WB-1:0] rom [ffd_pkg::TAPS][ENTRIES];

  for (genvar s = 0; s < ffd_pkg::TAPS; s++) begin : g_tab
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign rom[s][e] = WB'(ffd_pkg::basis_entry(s, e, LUT_AW, WFRAC));
    end
    assign wu[s] = rom[s][idx_u];
    assign wv[s] = rom[s][idx_v];
  end

endmodule

// File: rtl/ffd_pipe_mul.sv
module ffd_pipe_mul #(
  parameter int AW  = 17,
  parameter int BW  = 17,
  parameter int LAT = 6
) (
  input  logic                        clk,
  input  logic                        en,
  input  logic signed [AW-1:0]        a,
  input  logic signed [BW-1:0]        b,
  output logic signed [AW+BW-1:0]     p
);
  localparam int PW = AW + BW;

  logic signed [PW-1:0] st [LAT];

  always_ff @(posedge clk) begin
    if (en) begin
      st[0] <= a * b;
      for (int k = 1; k < LAT; k++) st[k] <= st[k-1];
    end
  end

  assign p = st[LAT-1];

endmodule

// File: rtl/ffd_sum_tree.sv
module ffd_sum_tree #(
  parameter int TW    = 33,
  parameter int OW    = 16,
  parameter int SHIFT = 15
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic [ffd_pkg::TERMS*TW-1:0]     terms,
  output logic signed [OW-1:0]             result
);
  localparam int GW   = TW + 2;
  localparam int SW   = TW + 4;
  localparam int NGRP = ffd_pkg::TERMS / 4;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SHIFT - 1);
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(64'sd1 <<< (OW - 1));

  logic signed [GW-1:0] grp_d [NGRP];
  logic signed [GW-1:0] grp_q [NGRP];
  logic signed [SW-1:0] tot_d;
  logic signed [SW-1:0] tot_q;
  logic signed [SW-1:0] rnd;
  logic signed [OW-1:0] sat_d;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      grp_d[g] = '0;
      for (int m = 0; m < 4; m++)
        grp_d[g] = grp_d[g] + GW'($signed(terms[(4*g+m)*TW +: TW]));
    end
  end

  always_comb begin
    tot_d = '0;
    for (int g = 0; g < NGRP; g++) tot_d = tot_d + SW'(grp_q[g]);
  end

  always_comb begin
    rnd = (tot_q + HALF) >>> SHIFT;
    if (rnd > MAXV)      sat_d = OW'(MAXV);
    else if (rnd < MINV) sat_d = OW'(MINV);
    else                 sat_d = OW'(rnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NGRP; g++) grp_q[g] <= '0;
      tot_q  <= '0;
      result <= '0;
    end else if (en) begin
      for (int g = 0; g < NGRP; g++) grp_q[g] <= grp_d[g];
      tot_q  <= tot_d;
      result <= sat_d;
    end
  end

endmodule

// File: rtl/ffd_bspline_pipe.sv
module ffd_bspline_pipe #(
  parameter int GRID_BITS = 4,
  parameter int FRAC_BITS = 12,
  parameter int LUT_AW    = 10,
  parameter int WB        = 16,
  parameter int WFRAC     = 15,
  parameter int DW        = 16,
  parameter int MUL_LAT   = ffd_pkg::MUL_LAT
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic [GRID_BITS+FRAC_BITS-1:0]              in_u,
  input  logic [GRID_BITS+FRAC_BITS-1:0]              in_v,
  output logic                                        cp_rd_en,
  output logic [2*GRID_BITS-1:0]                      cp_rd_addr,
  input  logic [ffd_pkg::TERMS*2*DW-1:0]              cp_rd_data,
  output logic                                        out_valid,
  input  logic                                        out_ready,
  output logic signed [DW-1:0]                        out_dx,
  output logic signed [DW-1:0]                        out_dy
);
  localparam int CW     = GRID_BITS + FRAC_BITS;
  localparam int AW     = 2 * GRID_BITS;
  localparam int TAPS   = ffd_pkg::TAPS;
  localparam int TERMS  = ffd_pkg::TERMS;
  localparam int DEPTH  = 1 + 2 * MUL_LAT + ffd_pkg::SUM_LAT;
  localparam int RD_POS = MUL_LAT - 1;
  localparam int P1W    = 2 * (WB + 1);
  localparam int P2W    = WB + 1 + DW;
  localparam logic [P1W-1:0] RND1 = P1W'(1) << (WFRAC - 1);

  logic                        adv;
  logic [DEPTH-1:0]            vld;
  logic [LUT_AW-1:0]           frac_u;
  logic [LUT_AW-1:0]           frac_v;
  logic [TAPS-1:0][WB-1:0]     wu;
  logic [TAPS-1:0][WB-1:0]     wv;
  logic [TAPS-1:0][WB-1:0]     bu_q;
  logic [TAPS-1:0][WB-1:0]     bv_q;
  logic [AW-1:0]               cel [MUL_LAT];
  logic signed [P1W-1:0]       p1  [TERMS];
  logic [WB-1:0]               wgt [TERMS];
  logic [TERMS*P2W-1:0]        terms [2];
  logic signed [DW-1:0]        res   [2];

  // Whole pipeline moves together; a held result freezes every stage.
  assign adv      = !vld[DEPTH-1] || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst)      vld <= '0;
    else if (adv) vld <= {vld[DEPTH-2:0], in_valid};
  end

  // Stage 1: split coordinates, look up all four basis values per axis.
  assign frac_u = in_u[FRAC_BITS-1 -: LUT_AW];
  assign frac_v = in_v[FRAC_BITS-1 -: LUT_AW];

  ffd_basis_lut #(.LUT_AW(LUT_AW), .WB(WB), .WFRAC(WFRAC)) u_lut (
    .idx_u (frac_u),
    .idx_v (frac_v),
    .wu    (wu),
    .wv    (wv)
  );

  always_ff @(posedge clk) begin
    if (adv) begin
      bu_q   <= wu;
      bv_q   <= wv;
      cel[0] <= {in_v[CW-1 -: GRID_BITS], in_u[CW-1 -: GRID_BITS]};
      for (int k = 1; k < MUL_LAT; k++) cel[k] <= cel[k-1];
    end
  end

  // Window read timed so data lands beside the finished tensor weights.
  assign cp_rd_en   = adv && vld[RD_POS];
  assign cp_rd_addr = cel[RD_POS];

  // Stage 2: tensor weights Bi(u)*Bj(v), rounded back to WFRAC bits.
  for (genvar k = 0; k < TERMS; k++) begin : g_wgt
    ffd_pipe_mul #(.AW(WB+1), .BW(WB+1), .LAT(MUL_LAT)) u_mul_w (
      .clk (clk),
      .en  (adv),
      .a   ($signed({1'b0, bu_q[k % TAPS]})),
      .b   ($signed({1'b0, bv_q[k / TAPS]})),
      .p   (p1[k])
    );
    assign wgt[k] = WB'((P1W'(p1[k]) + RND1) >> WFRAC);
  end

  // Stage 3: weight times displacement, per axis (c=0 x, c=1 y).
  for (genvar c = 0; c < 2; c++) begin : g_axis
    for (genvar k = 0; k < TERMS; k++) begin : g_term
      logic signed [P2W-1:0] prod;
      ffd_pipe_mul #(.AW(WB+1), .BW(DW), .LAT(MUL_LAT)) u_mul_d (
        .clk (clk),
        .en  (adv),
        .a   ($signed({1'b0, wgt[k]})),
        .b   ($signed(cp_rd_data[(2*k+c)*DW +: DW])),
        .p   (prod)
      );
      assign terms[c][k*P2W +: P2W] = prod;
    end

    // Stage 4: reduce sixteen terms, round, saturate.
    ffd_sum_tree #(.TW(P2W), .OW(DW), .SHIFT(WFRAC)) u_tree (
      .clk    (clk),
      .rst    (rst),
      .en     (adv),
      .terms  (terms[c]),
      .result (res[c])
    );
  end

  assign out_valid = vld[DEPTH-1];
  assign out_dx    = res[0];
  assign out_dy    = res[1];

endmodule

// File: rtl/ffd_bspline_chk.sv
module ffd_bspline_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_dx,
  input logic signed [DW-1:0] out_dy,
  input logic                 cp_rd_en
);
  localparam int CNTW = $clog2(DEPTH + 1) + 1;

  logic [CNTW-1:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + CNTW'(in_valid && in_ready)
                              - CNTW'(out_valid && out_ready);
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready && out_dx == '0 && out_dy == '0));

  assert_hold_under_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dx) && $stable(out_dy)));

  assert_drop_after_take_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));

  assert_read_while_moving_R5: assert property (@(posedge clk) disable iff (rst)
    cp_rd_en |-> (!out_valid || out_ready));

  assert_inflight_bound_R3: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNTW'(DEPTH));

endmodule

bind ffd_bspline_pipe ffd_bspline_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dx    (out_dx),
  .out_dy    (out_dy),
  .cp_rd_en  (cp_rd_en)
);

// File: tb/tb_ffd_bspline_pipe.sv
`timescale 1ns/1ps
module tb_ffd_bspline_pipe;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic               in_ready;
  logic [15:0]        in_u;
  logic [15:0]        in_v;
  logic               cp_rd_en;
  logic [7:0]         cp_rd_addr;
  logic [511:0]       cp_rd_data;
  logic               out_valid;
  logic               out_ready;
  logic signed [15:0] out_dx;
  logic signed [15:0] out_dy;

  always #4 clk = ~clk;

  ffd_bspline_pipe dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_u(in_u), .in_v(in_v), .cp_rd_en(cp_rd_en), .cp_rd_addr(cp_rd_addr),
    .cp_rd_data(cp_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_dx(out_dx), .out_dy(out_dy)
  );

  int    nvec = 0;
  int    nfail = 0;
  int    mode = 0;
  bit    stall = 0;
  bit    done = 0;
  string cur_req = "R10";

  // ---------------- reference arithmetic from the requirements ----------
  function automatic longint basis(int s, int n);
    longint t, nn, num;
    t = n; nn = 1024;
    if (s == 0)      num = (nn - t) ** 3;
    else if (s == 1) num = 3 * t ** 3 - 6 * t * t * nn + 4 * nn ** 3;
    else if (s == 2) num = -3 * t ** 3 + 3 * t * t * nn + 3 * t * nn * nn + nn ** 3;
    else             num = t ** 3;
    return (num + 98304) / 196608;
  endfunction

  function automatic logic signed [15:0] phi(int md, int addr, int k, int c);
    logic [31:0] h;
    if (md == 1) return 16'sh7FFF;
    if (md == 2) return 16'sh8000;
    if (md == 3 && c == 1) return 16'sh0000;
    h = addr * 32'h9E3779B1 ^ (k * 32'h85EB + c * 32'h3D1 + 32'h55);
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 12);
    return signed'(h[15:0]);
  endfunction

  task automatic ref_point(input logic [15:0] u, input logic [15:0] v,
                           output logic signed [15:0] rx,
                           output logic signed [15:0] ry, output int addr);
    int fu, fv;
    longint s, w, r;
    fu = int'(u[11:2]);
    fv = int'(v[11:2]);
    addr = int'(v[15:12]) * 16 + int'(u[15:12]);
    for (int c = 0; c < 2; c++) begin
      s = 0;
      for (int j = 0; j < 4; j++)
        for (int i = 0; i < 4; i++) begin
          w = (basis(i, fu) * basis(j, fv) + 16384) >>> 15;
          s += w * longint'(phi(mode, addr, 4 * j + i, c));
        end
      r = (s + 16384) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      if (c == 0) rx = 16'(r); else ry = 16'(r);
    end
  endtask

  // ---------------- control-window memory model ------------------------
  always @(posedge clk) begin
    if (cp_rd_en) begin
      for (int k = 0; k < 16; k++)
        for (int c = 0; c < 2; c++)
          cp_rd_data[(2*k+c)*16 +: 16] <= phi(mode, int'(cp_rd_addr), k, c);
    end
  end

  // ---------------- consumer back-pressure -------------------------------
  always @(posedge clk) begin
    #2 out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
  end

  // ---------------- cycle model, compared every clock --------------------
  bit                 mv [16];
  logic signed [15:0] mx [16];
  logic signed [15:0] my [16];
  logic [7:0]         ma [16];
  bit                 armed = 0;

  always @(negedge clk) begin : model
    bit adv;
    logic signed [15:0] ex, ey;
    int ea;
    adv = !mv[15] || out_ready;
    if (armed) begin
      nvec++;
      if (out_valid !== mv[15]) begin
        nfail++;
        $display("FAIL R3 out_valid actual %b expected %b", out_valid, mv[15]);
      end else if (mv[15] && (out_dx !== mx[15] || out_dy !== my[15])) begin
        nfail++;
        $display("FAIL %s result actual (%0d,%0d) expected (%0d,%0d)",
                 cur_req, out_dx, out_dy, mx[15], my[15]);
      end
      if (in_ready !== adv) begin
        nfail++;
        $display("FAIL R2 in_ready actual %b expected %b", in_ready, adv);
      end
      if (cp_rd_en !== (adv && mv[5])) begin
        nfail++;
        $display("FAIL R5 cp_rd_en actual %b expected %b", cp_rd_en, adv && mv[5]);
      end else if (cp_rd_en && cp_rd_addr !== ma[5]) begin
        nfail++;
        $display("FAIL R5 cp_rd_addr actual %0h expected %0h", cp_rd_addr, ma[5]);
      end
    end
    if (rst) begin
      for (int k = 0; k < 16; k++) mv[k] = 0;
      armed = 1;
    end else if (adv) begin
      for (int k = 15; k > 0; k--) begin
        mv[k] = mv[k-1]; mx[k] = mx[k-1]; my[k] = my[k-1]; ma[k] = ma[k-1];
      end
      mv[0] = in_valid;
      if (in_valid) begin
        ref_point(in_u, in_v, ex, ey, ea);
        mx[0] = ex; my[0] = ey; ma[0] = 8'(ea);
      end
    end
  end

  // ---------------- stimulus helpers -------------------------------------
  task automatic send(input logic [15:0] u, input logic [15:0] v);
    bit acc;
    in_valid = 1'b1; in_u = u; in_v = v;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #2;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic drain();
    stall = 0;
    idle(30);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    int sat_f;
    longint tot;
    rst = 1'b1; in_valid = 1'b0; in_u = '0; in_v = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1: state straight after reset
    @(negedge clk);
    nvec++;
    if (out_valid !== 1'b0 || out_dx !== 16'sd0 || out_dy !== 16'sd0 || in_ready !== 1'b1) begin
      nfail++;
      $display("FAIL R1 reset state actual v=%b dx=%0d dy=%0d rdy=%b expected 0,0,0,1",
               out_valid, out_dx, out_dy, in_ready);
    end
    @(posedge clk); #2;

    // R10 R9 R6 R3: back-to-back random points
    cur_req = "R10";
    for (int n = 0; n < 40; n++) send(16'($urandom), 16'($urandom));
    drain();

    // R7: table ends and grid edge cells
    cur_req = "R7";
    send(16'h0000, 16'h0000);
    send(16'hFFFF, 16'hFFFF);
    send(16'h0FFC, 16'hF000);
    send(16'hF003, 16'h0FFF);
    send(16'h0800, 16'h0800);
    drain();

    // R8: lowest two fraction bits must not change the result
    cur_req = "R8";
    for (int n = 0; n < 6; n++) begin
      logic [15:0] u, v;
      u = 16'($urandom) & 16'hFFFC;
      v = 16'($urandom) & 16'hFFFC;
      send(u, v);
      send(u | 16'h0003, v | 16'h0002);
    end
    drain();

    // R4 R2: random back-pressure and idle gaps
    cur_req = "R4";
    stall = 1;
    for (int n = 0; n < 60; n++) begin
      send(16'($urandom), 16'($urandom));
      idle($urandom % 3);
    end
    drain();

    // R11: extreme displacement fields, including a saturating weight sum
    cur_req = "R11";
    sat_f = -1;
    for (int f = 0; f < 1024 && sat_f < 0; f++) begin
      tot = 0;
      for (int j = 0; j < 4; j++)
        for (int i = 0; i < 4; i++)
          tot += (basis(i, f) * basis(j, f) + 16384) >>> 15;
      if (tot > 32768) sat_f = f;
    end
    mode = 1;
    for (int n = 0; n < 10; n++) send(16'($urandom), 16'($urandom));
    drain();
    mode = 2;
    if (sat_f >= 0) send(16'((sat_f << 2) | 16'h3000), 16'((sat_f << 2) | 16'h5000));
    for (int n = 0; n < 10; n++) send(16'($urandom), 16'($urandom));
    drain();

    // R12: y field zero, x field live
    cur_req = "R12";
    mode = 3;
    for (int n = 0; n < 20; n++) send(16'($urandom), 16'($urandom));
    drain();

    // R1: reset while points are in flight
    cur_req = "R1";
    mode = 0;
    stall = 1;
    for (int n = 0; n < 8; n++) send(16'($urandom), 16'($urandom));
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    stall = 0;
    for (int n = 0; n < 10; n++) send(16'($urandom), 16'($urandom));
    drain();

    finish_run();
  end

endmodule